// File: doc/BRIEF.md
# Parallel Flash Write-Cycle Timing Generator

This block performs single asynchronous write cycles on a parallel NOR-flash-style bus. A host presents an address and a data word and raises a start strobe for one clock. The block then drives the active-low chip enable, write enable and output enable lines, the address bus and the data bus. It holds each of them long enough that every minimum interval of the bus is met.

All timing is counted in cycles of the block's clock, and the clock period is a parameter. Each nanosecond minimum becomes the ceiling of that value divided by the period, and is never less than one cycle. From those counts the block derives the strobe-low length and the total cycle length. A mode input, sampled when a start is accepted, picks the line that carries the write strobe. The other line acts as the enclosing enable.

A busy flag covers the whole cycle. A one-clock done pulse marks its end. A start that is held in the final clock of a cycle is taken at once, so writes can run back to back at the minimum cycle time.

Top module: `flash_wr_timer`

## Requirements
- R1: After reset, ce_n, we_n and oe_n are 1, data_oe is 0, and busy and done are 0.
- R2: With mode = 0 (write-enable strobe) and defaults (5 ns clock), ce_n falls at the clock edge that accepts start. we_n falls one edge later and stays low for 7 cycles. Both lines rise together at the same edge.
- R3: With mode = 1 (chip-enable strobe), the same timing applies with the roles of ce_n and we_n swapped. we_n encloses the strobe and ce_n is the strobe.
- R4: data_oe is 1 from the accept edge until the strobe rises, and 0 at all other times. While data_oe is 1, data_out equals the data_in value captured at the accept edge.
- R5: addr equals the addr_in value captured at the accept edge. It holds that value unchanged until the next accepted start.
- R6: oe_n is 1 throughout every write cycle, including every cycle in which the strobe is low.
- R7: busy is 1 for 12 cycles from the accept edge (60 ns at defaults). done is a one-cycle pulse that is 1 in the cycle after the last busy cycle and 0 at all other times.
- R8: A start that arrives while busy, other than in the final cycle, has no effect. The address, the data and the timing of the running cycle are unchanged, and no extra cycle follows.
- R9: A start held in the final busy cycle is accepted at the same edge that raises done. In that case busy stays 1 and the next cycle begins exactly 12 cycles after the previous accept.
- R10: In back-to-back writes the strobe stays high for at least 4 cycles (20 ns at defaults) between its rising edge and its next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a write cycle |
| mode | input | 1 | 0 = write enable strobes the write, 1 = chip enable strobes it |
| addr_in | input | ADDR_W | Address of the write |
| data_in | input | DATA_W | Data of the write |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | ADDR_W | Address bus |
| data_out | output | DATA_W | Data bus value |
| data_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| busy | output | 1 | A write cycle is in progress |
| done | output | 1 | One-cycle pulse at the end of a write cycle |

## Verification
The end of one write and the start of the next can fall on the same clock edge. At that edge the done pulse is raised while a new start is accepted. The bench provokes this by holding start during the final busy cycle, with a different mode and new address and data. It then checks three things: done rises while busy stays high, the new cycle's enable falls at that same edge, and the new strobe falls only after the previous strobe has been high for the recovery time.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } phase_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned r;
        r = (ns + period - 1) / period;
        if (r < 1) r = 1;
        return r;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fwt_bus_hold.sv
module fwt_bus_hold #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (capture) begin
            hold_d.addr = addr_i;
            hold_d.data = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign addr_o = hold_q.addr;
    assign data_o = hold_q.data;

endmodule

// File: rtl/fwt_sequencer.sv
module fwt_sequencer
    import flash_wr_pkg::*;
#(
    parameter int unsigned LOW_CYC  = 7,
    parameter int unsigned HIGH_CYC = 4,
    parameter int unsigned REC_CYC  = 4,
    parameter int unsigned CYC_CYC  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode,
    output logic accept,
    output logic ce_n,
    output logic we_n,
    output logic oe_n,
    output logic drive,
    output logic busy,
    output logic done
);

    localparam int unsigned CNT_MAX = max_u(LOW_CYC, HIGH_CYC);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             mode;
        logic             ce_n;
        logic             we_n;
        logic             oe_n;
        logic             drive;
        logic             busy;
        logic             done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.oe_n = 1'b1;
        accept     = 1'b0;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start) accept = 1'b1;
            end
            PH_SETUP: begin
                seq_d.phase = PH_LOW;
                seq_d.cnt   = CNT_W'(LOW_CYC - 1);
                if (seq_q.mode) seq_d.ce_n = 1'b0;
                else            seq_d.we_n = 1'b0;
            end
            PH_LOW: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_HIGH;
                    seq_d.cnt   = CNT_W'(HIGH_CYC - 1);
                    seq_d.ce_n  = 1'b1;
                    seq_d.we_n  = 1'b1;
                    seq_d.drive = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_HIGH: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_IDLE;
                    seq_d.busy  = 1'b0;
                    seq_d.done  = 1'b1;
                    if (start) accept = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
        if (accept) begin
            seq_d.phase = PH_SETUP;
            seq_d.cnt   = '0;
            seq_d.mode  = mode;
            seq_d.busy  = 1'b1;
            seq_d.drive = 1'b1;
            seq_d.ce_n  = mode;
            seq_d.we_n  = ~mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
            seq_q.ce_n  <= 1'b1;
            seq_q.we_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ce_n  = seq_q.ce_n;
    assign we_n  = seq_q.we_n;
    assign oe_n  = seq_q.oe_n;
    assign drive = seq_q.drive;
    assign busy  = seq_q.busy;
    assign done  = seq_q.done;

    // Checker counters measuring pin intervals in cycles.
    logic        strobe_n;
    logic        enable_n;
    logic [15:0] low_run_q;
    logic [15:0] high_run_q;
    logic [15:0] since_acc_q;
    logic        seen_rise_q;
    logic        seen_acc_q;

    assign strobe_n = seq_q.mode ? seq_q.ce_n : seq_q.we_n;
    assign enable_n = seq_q.mode ? seq_q.we_n : seq_q.ce_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q   <= '0;
            high_run_q  <= '0;
            since_acc_q <= '0;
            seen_rise_q <= 1'b0;
            seen_acc_q  <= 1'b0;
        end else begin
            low_run_q  <= strobe_n ? 16'd0 : low_run_q + 16'd1;
            high_run_q <= strobe_n ? high_run_q + 16'd1 : 16'd0;
            if (!strobe_n && seq_d.ce_n && seq_d.we_n) seen_rise_q <= 1'b1;
            if (accept) begin
                since_acc_q <= 16'd1;
                seen_acc_q  <= 1'b1;
            end else if (since_acc_q != 16'hFFFF) begin
                since_acc_q <= since_acc_q + 1'b1;
            end
        end
    end

    AST_STROBE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && seq_d.ce_n && seq_d.we_n) |-> (low_run_q + 16'd1 >= 16'(LOW_CYC))); // R2
    AST_ENABLE_ENCLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> !enable_n); // R3
    AST_OE_HIGH_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n || !we_n) |-> oe_n); // R6
    AST_DATA_DRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> drive); // R4
    AST_RECOVERY_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_rise_q && strobe_n && ((seq_d.mode ? seq_d.ce_n : seq_d.we_n) == 1'b0))
        |-> (high_run_q + 16'd1 >= 16'(REC_CYC))); // R10
    AST_CYCLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && seen_acc_q) |-> (since_acc_q >= 16'(CYC_CYC))); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R7

endmodule

// File: rtl/flash_wr_timer.sv
module flash_wr_timer
    import flash_wr_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS    = 5,
    parameter int unsigned T_CYCLE_NS       = 60,
    parameter int unsigned T_STROBE_LOW_NS  = 35,
    parameter int unsigned T_STROBE_HIGH_NS = 20,
    parameter int unsigned T_DATA_SETUP_NS  = 30,
    parameter int unsigned T_ADDR_HOLD_NS   = 45,
    parameter int          ADDR_W           = 24,
    parameter int          DATA_W           = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              busy,
    output logic              done
);

    localparam int unsigned WP_C  = ns_to_cyc(T_STROBE_LOW_NS, CLK_PERIOD_NS);
    localparam int unsigned WPH_C = ns_to_cyc(T_STROBE_HIGH_NS, CLK_PERIOD_NS);
    localparam int unsigned DS_C  = ns_to_cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned AH_C  = ns_to_cyc(T_ADDR_HOLD_NS, CLK_PERIOD_NS);
    localparam int unsigned WC_C  = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
    // The setup cycle already counts toward data setup.
    localparam int unsigned LOW_C = max_u(WP_C, DS_C - 1);
    localparam int unsigned CYC_C = max_u(WC_C, max_u(1 + LOW_C + WPH_C, 1 + AH_C));
    localparam int unsigned HIGH_C = CYC_C - 1 - LOW_C;

    logic accept;

    fwt_sequencer #(
        .LOW_CYC (LOW_C),
        .HIGH_CYC(HIGH_C),
        .REC_CYC (WPH_C),
        .CYC_CYC (CYC_C)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .mode  (mode),
        .accept(accept),
        .ce_n  (ce_n),
        .we_n  (we_n),
        .oe_n  (oe_n),
        .drive (data_oe),
        .busy  (busy),
        .done  (done)
    );

    fwt_bus_hold #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(accept),
        .addr_i (addr_in),
        .data_i (data_in),
        .addr_o (addr),
        .data_o (data_out)
    );

    AST_ADDR_STABLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> ((ce_n || we_n) || $stable(addr))); // R5
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !data_oe); // R4

endmodule

// File: tb/flash_wr_timer_tb.sv
module flash_wr_timer_tb;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int PER    = 5;

    function automatic int cyc(input int ns);
        int r;
        r = (ns + PER - 1) / PER;
        return (r < 1) ? 1 : r;
    endfunction

    localparam int LOW_E = (cyc(35) > cyc(30) - 1) ? cyc(35) : cyc(30) - 1;
    localparam int CYC_E = 12;

    typedef struct {
        bit                mode;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        bit                ign;
        bit                b2b;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mode = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [DATA_W-1:0] data_in = '0;
    logic              ce_n, we_n, oe_n, data_oe, busy, done;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data_out;

    flash_wr_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_in(addr_in), .data_in(data_in),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
        .data_out(data_out), .data_oe(data_oe), .busy(busy), .done(done)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    pushed = 0;
    int    finished = 0;
    item_t expq[$];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: follows each cycle from its data_oe rise.
    item_t cur;
    int    ph = 0;
    bit    act = 0;
    logic  prev_oe = 1'b0;

    task automatic check_phase();
        logic  strb, enb;
        string rq;
        strb = cur.mode ? ce_n : we_n;
        enb  = cur.mode ? we_n : ce_n;
        rq   = cur.mode ? "R3" : "R2";
        if (ph < CYC_E) begin
            chk((ph == 0 && cur.b2b) ? "R10" : rq, "strobe", 32'(strb), (ph >= 1 && ph <= LOW_E) ? 0 : 1);
            chk(rq, "enable", 32'(enb), (ph <= LOW_E) ? 0 : 1);
            chk(cur.ign ? "R8" : "R5", "addr", 32'(addr), 32'(cur.a));
            chk("R7", "busy", 32'(busy), 1);
            chk("R6", "oe_n", 32'(oe_n), 1);
            chk("R4", "data_oe", 32'(data_oe), (ph <= LOW_E) ? 1 : 0);
            if (ph <= LOW_E) chk(cur.ign ? "R8" : "R4", "data", 32'(data_out), 32'(cur.d));
            if (ph > 0) chk("R7", "done", 32'(done), 0);
        end else begin
            chk("R7", "done end", 32'(done), 1);
            chk("R9", "busy end", 32'(busy), 32'(data_oe));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (act) begin
                ph++;
                check_phase();
                if (ph == CYC_E) begin
                    act = 0;
                    finished++;
                end
            end
            if (data_oe && !prev_oe) begin
                if (expq.size() == 0) begin
                    chk("R8", "unexpected cycle", 1, 0);
                end else begin
                    cur = expq.pop_front();
                    act = 1;
                    ph  = 0;
                    check_phase();
                end
            end
            prev_oe = data_oe;
        end
    end

    // Driver tasks: all start at a negedge.
    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic push(input bit m, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input bit ign, input bit b2b);
        item_t it;
        it.mode = m; it.a = a; it.d = d; it.ign = ign; it.b2b = b2b;
        expq.push_back(it);
        pushed++;
        start = 1'b1; mode = m; addr_in = a; data_in = d;
    endtask

    task automatic write1(input bit m, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wait_idle();
        push(m, a, d, 0, 0);
        @(negedge clk);
        start = 1'b0;
        addr_in = ~a; data_in = ~d;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 50000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ce_n", 32'(ce_n), 1);
        chk("R1", "we_n", 32'(we_n), 1);
        chk("R1", "oe_n", 32'(oe_n), 1);
        chk("R1", "data_oe", 32'(data_oe), 0);
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        write1(0, 24'h123456, 16'hA5C3);
        write1(1, 24'hABCDEF, 16'h5A3C);
        write1(0, 24'hFFFFFF, 16'hFFFF);
        write1(1, 24'h000000, 16'h0000);

        // R8: start mid-cycle with other values must be ignored.
        wait_idle();
        push(0, 24'h0F0F0F, 16'h1234, 1, 0);
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; mode = 1'b1; addr_in = 24'hDEAD00; data_in = 16'hBEEF;
        repeat (2) @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8", "idle after ignored start", 32'(busy), 0);

        // R9/R10: back-to-back, mode switch at the shared edge.
        wait_idle();
        push(0, 24'h111111, 16'h2222, 0, 0);
        @(negedge clk);
        start = 1'b0;
        repeat (CYC_E - 1) @(negedge clk);
        push(1, 24'h333333, 16'h4444, 0, 1);
        @(negedge clk);
        start = 1'b0;
        repeat (CYC_E - 1) @(negedge clk);
        push(0, 24'h555555, 16'h6666, 0, 1);
        @(negedge clk);
        start = 1'b0;

        wait_idle();
        repeat (4) @(negedge clk);
        chk("R7", "done idle", 32'(done), 0);
        chk("R4", "data_oe idle", 32'(data_oe), 0);
        chk("R5", "addr held after cycle", 32'(addr), 32'(24'h555555));
        chk("R8", "cycles completed", 32'(finished), 32'(pushed));
        chk("R8", "queue empty", 32'(expq.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule